// File: doc/BRIEF.md
# Link Request Handler for a Serial Bus PHY

This block sits on the physical-layer side of a serial bus node. It takes bus-access and register-access requests from the link layer, which sends them one bit per clock on a single request line. It decodes each frame and holds at most one pending bus request. When arbitration finishes, it reports whether the request won or lost.

Register requests go to a small local register file. A write lands as soon as its frame ends. A read is answered by a serial status transfer that starts when the bus is idle. If an incoming packet breaks into a status transfer, the transfer is abandoned and started again from its first bit.

Cable signalling, tree arbitration and the packet datapath live elsewhere. The block only sees their results: an idle indication, the receive line state, arbitration-won and transmit-start signals.

Top module: `phy_link_req`

## Requirements
- R1: A request frame is a start bit of 1, then a 3-bit kind code sent MSB first (1 immediate, 2 isochronous, 3 priority, 4 fair, 5 register read, 6 register write). A bus frame then carries 3 pad bits and a stop bit, 8 bits in all. A register frame carries a 4-bit address and 8-bit data, each MSB first, then a stop bit, 17 bits in all. A valid bus request is shown on `reqPending`/`pendKind` two clocks after its stop bit is sampled.
- R2: Only one bus request is held at a time. A bus request that completes while one is pending is ignored, and `pendKind` keeps the first kind.
- R3: A priority or fair request is discarded if `rxState` is high in any cycle from its start bit through its stop bit. Immediate and isochronous requests are kept.
- R4: While an immediate, priority or fair request is pending, `arbWon` produces a one-cycle `wonPulse` on the next clock and clears the request. `wonPulse` and `lostPulse` never fire together.
- R5: A rising edge of `rxState` while an immediate, priority or fair request is pending produces a one-cycle `lostPulse` and clears the request. A receive state that is already high when the request becomes pending causes no loss.
- R6: An isochronous request ignores `rxState`. On `arbWon` it gives `wonPulse` but stays pending. It then clears on `txStart`, or after `ISO_IDLE_CYC` consecutive `busIdle` cycles (default 4).
- R7: A register write stores its data into the addressed register when the frame completes.
- R8: A register read starts a status transfer in the first cycle with `busIdle` high and `rxState` low. `statActive` is then high for 12 cycles while `statBit` shows the 4-bit address followed by the 8-bit register contents, MSB first.
- R9: `rxState` high during a status transfer aborts it on the next clock, and the transfer restarts from its first bit once the bus is idle again. A read that completes while another read is still unanswered is ignored.
- R10: After reset no request is pending, all pulses and status outputs are low, and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLine | input | 1 | Serial request line from the link layer |
| rxState | input | 1 | PHY is signalling receive on the control lines |
| busIdle | input | 1 | Bus is idle |
| arbWon | input | 1 | Arbitration for the pending request was won |
| txStart | input | 1 | A packet transmission has started |
| reqPending | output | 1 | A bus request is being held |
| pendKind | output | 3 | Kind code of the held request, 0 when none |
| wonPulse | output | 1 | One-cycle won indication |
| lostPulse | output | 1 | One-cycle lost indication |
| statActive | output | 1 | Status transfer in progress |
| statBit | output | 1 | Serial status data, MSB first |

## Verification
The hardest case to reach is a status transfer cut off part way through and then resent. The bench gets there by holding `busIdle` low while the read frame arrives, so the read waits. It then opens the idle window, lets a few status bits out, and raises `rxState` for one cycle. It checks that the transfer stops, and that the retry starts from the address MSB with the full 12 bits. A second hard case is the isochronous idle timeout: the bench wins arbitration with the line idle and counts the exact cycle in which the hold is released.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_IMM   = 3'd1,
    K_ISO   = 3'd2,
    K_PRIO  = 3'd3,
    K_FAIR  = 3'd4,
    K_READ  = 3'd5,
    K_WRITE = 3'd6,
    K_RSVD  = 3'd7
  } reqKind_e;

  // decoded frame, datapath -> control
  typedef struct packed {
    logic              valid;
    reqKind_e          kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              rxSeen;
  } frame_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic              regWr;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              statLoad;
    logic              statAbort;
    logic [ADDR_W-1:0] rdAddr;
  } strobe_t;

  function automatic logic isRegKind(input logic [2:0] k);
    return (k == K_READ) || (k == K_WRITE);
  endfunction
endpackage

// File: rtl/lrq_datapath.sv
module lrq_datapath
  import lrq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqLine,
  input  logic    rxState,
  input  strobe_t stb,
  output frame_t  frame,
  output logic    statActive,
  output logic    statBit,
  output logic    statFinish
);
  localparam int REG_BITS  = 3 + ADDR_W + DATA_W + 1;  // payload after start bit
  localparam int BUS_BITS  = 3 + 3 + 1;
  localparam int CNT_W     = $clog2(REG_BITS);
  localparam int STAT_BITS = ADDR_W + DATA_W;
  localparam int SC_W      = $clog2(STAT_BITS);
  localparam int REGS      = 1 << ADDR_W;

  logic                 shifting, regFrame, rxSeen, frameDone;
  logic [CNT_W-1:0]     cnt, lastIdx;
  logic [REG_BITS-1:0]  shReg;
  logic [DATA_W-1:0]    regs [REGS];
  logic [STAT_BITS-1:0] statSh;
  logic [SC_W-1:0]      statCnt;

  assign lastIdx = regFrame ? CNT_W'(REG_BITS - 1) : CNT_W'(BUS_BITS - 1);

  // request deserializer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shifting  <= 1'b0;
      regFrame  <= 1'b0;
      rxSeen    <= 1'b0;
      frameDone <= 1'b0;
      cnt       <= '0;
      shReg     <= '0;
    end else begin
      frameDone <= shifting && (cnt == lastIdx);
      if (!shifting) begin
        if (reqLine) begin
          shifting <= 1'b1;
          cnt      <= '0;
          rxSeen   <= rxState;
        end
      end else begin
        shReg  <= {shReg[REG_BITS-2:0], reqLine};
        cnt    <= cnt + 1'b1;
        rxSeen <= rxSeen | rxState;
        if (cnt == CNT_W'(3)) regFrame <= isRegKind(shReg[2:0]);
        if (cnt == lastIdx) shifting <= 1'b0;
      end
    end
  end

  always_comb begin
    frame.valid  = frameDone;
    frame.kind   = regFrame ? reqKind_e'(shReg[REG_BITS-1 -: 3])
                            : reqKind_e'(shReg[BUS_BITS-1 -: 3]);
    frame.addr   = shReg[DATA_W+ADDR_W -: ADDR_W];
    frame.data   = shReg[DATA_W:1];
    frame.rxSeen = rxSeen;
  end

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
    end else if (stb.regWr) begin
      regs[stb.wrAddr] <= stb.wrData;
    end
  end

  // status transfer shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statActive <= 1'b0;
      statSh     <= '0;
      statCnt    <= '0;
    end else if (stb.statLoad) begin
      statActive <= 1'b1;
      statSh     <= {stb.rdAddr, regs[stb.rdAddr]};
      statCnt    <= '0;
    end else if (statActive) begin
      if (stb.statAbort || statFinish) begin
        statActive <= 1'b0;
      end else begin
        statSh  <= statSh << 1;
        statCnt <= statCnt + 1'b1;
      end
    end
  end

  assign statFinish = statActive && (statCnt == SC_W'(STAT_BITS - 1));
  assign statBit    = statActive & statSh[STAT_BITS-1];
endmodule

// File: rtl/lrq_control.sv
module lrq_control
  import lrq_pkg::*;
#(
  parameter int ISO_IDLE_CYC = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxState,
  input  logic     busIdle,
  input  logic     arbWon,
  input  logic     txStart,
  input  frame_t   frame,
  input  logic     statActive,
  input  logic     statFinish,
  output strobe_t  stb,
  output logic     reqPending,
  output reqKind_e pendKind,
  output logic     wonPulse,
  output logic     lostPulse
);
  localparam int IDLE_W = $clog2(ISO_IDLE_CYC + 1);

  logic              pending, isoHeld, rxPrev, readPend;
  reqKind_e          kindQ;
  logic [IDLE_W-1:0] idleCnt;
  logic [ADDR_W-1:0] rdAddrQ;
  logic              busReq, dropRx, rxRise;

  assign busReq = frame.valid && (frame.kind inside {K_IMM, K_ISO, K_PRIO, K_FAIR});
  assign dropRx = (frame.kind inside {K_PRIO, K_FAIR}) && frame.rxSeen;
  assign rxRise = rxState && !rxPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      isoHeld   <= 1'b0;
      kindQ     <= K_NONE;
      idleCnt   <= '0;
      rxPrev    <= 1'b0;
      wonPulse  <= 1'b0;
      lostPulse <= 1'b0;
    end else begin
      wonPulse  <= 1'b0;
      lostPulse <= 1'b0;
      rxPrev    <= rxState;
      if (!pending) begin
        if (busReq && !dropRx) begin
          pending <= 1'b1;
          kindQ   <= frame.kind;
          isoHeld <= 1'b0;
          idleCnt <= '0;
        end
      end else if (isoHeld) begin
        if (txStart) begin
          pending <= 1'b0;
          isoHeld <= 1'b0;
        end else if (busIdle) begin
          if (idleCnt == IDLE_W'(ISO_IDLE_CYC - 1)) begin
            pending <= 1'b0;
            isoHeld <= 1'b0;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end else begin
          idleCnt <= '0;
        end
      end else if (arbWon) begin
        wonPulse <= 1'b1;
        if (kindQ == K_ISO) begin
          isoHeld <= 1'b1;
          idleCnt <= '0;
        end else begin
          pending <= 1'b0;
        end
      end else if (rxRise && kindQ != K_ISO) begin
        lostPulse <= 1'b1;
        pending   <= 1'b0;
      end
    end
  end

  // register read bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readPend <= 1'b0;
      rdAddrQ  <= '0;
    end else if (frame.valid && frame.kind == K_READ && !readPend) begin
      readPend <= 1'b1;
      rdAddrQ  <= frame.addr;
    end else if (readPend && statFinish && !rxState) begin
      readPend <= 1'b0;
    end
  end

  always_comb begin
    stb.regWr     = frame.valid && (frame.kind == K_WRITE);
    stb.wrAddr    = frame.addr;
    stb.wrData    = frame.data;
    stb.statLoad  = readPend && !statActive && busIdle && !rxState;
    stb.statAbort = statActive && rxState;
    stb.rdAddr    = rdAddrQ;
  end

  assign reqPending = pending;
  assign pendKind   = pending ? kindQ : K_NONE;
endmodule

// File: rtl/phy_link_req.sv
module phy_link_req
  import lrq_pkg::*;
#(
  parameter int ISO_IDLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqLine,
  input  logic       rxState,
  input  logic       busIdle,
  input  logic       arbWon,
  input  logic       txStart,
  output logic       reqPending,
  output logic [2:0] pendKind,
  output logic       wonPulse,
  output logic       lostPulse,
  output logic       statActive,
  output logic       statBit
);
  frame_t   frame;
  strobe_t  stb;
  reqKind_e kindE;
  logic     statFinish;

  lrq_datapath u_dp (
    .clk(clk), .rstN(rstN), .reqLine(reqLine), .rxState(rxState), .stb(stb),
    .frame(frame), .statActive(statActive), .statBit(statBit), .statFinish(statFinish)
  );

  lrq_control #(.ISO_IDLE_CYC(ISO_IDLE_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .rxState(rxState), .busIdle(busIdle), .arbWon(arbWon),
    .txStart(txStart), .frame(frame), .statActive(statActive), .statFinish(statFinish),
    .stb(stb), .reqPending(reqPending), .pendKind(kindE), .wonPulse(wonPulse),
    .lostPulse(lostPulse)
  );

  assign pendKind = kindE;
endmodule

// File: rtl/lrq_checker.sv
module lrq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rxState,
  input logic       busIdle,
  input logic       arbWon,
  input logic       reqPending,
  input logic [2:0] pendKind,
  input logic       wonPulse,
  input logic       lostPulse,
  input logic       statActive
);
  AST_WON_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    wonPulse |-> $past(reqPending && arbWon)); // R4
  AST_WON_LOST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(wonPulse && lostPulse)); // R4
  AST_LOST_ON_RX: assert property (@(posedge clk) disable iff (!rstN)
    lostPulse |-> ($past(reqPending && rxState) && !reqPending)); // R5
  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (reqPending && $past(reqPending)) |-> $stable(pendKind)); // R2
  AST_STAT_START_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statActive) |-> $past(busIdle && !rxState)); // R8
  AST_STAT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (statActive && rxState) |=> !statActive); // R9
endmodule

bind phy_link_req lrq_checker u_chk (
  .clk(clk), .rstN(rstN), .rxState(rxState), .busIdle(busIdle), .arbWon(arbWon),
  .reqPending(reqPending), .pendKind(pendKind), .wonPulse(wonPulse),
  .lostPulse(lostPulse), .statActive(statActive)
);

// File: tb/tb_phy_link_req.sv
module tb_phy_link_req;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqLine = 1'b0, rxState = 1'b0, busIdle = 1'b0, arbWon = 1'b0, txStart = 1'b0;
  logic reqPending, wonPulse, lostPulse, statActive, statBit;
  logic [2:0] pendKind;
  int checks = 0, fails = 0;
  logic [11:0] got;

  phy_link_req #(.ISO_IDLE_CYC(4)) dut (
    .clk(clk), .rstN(rstN), .reqLine(reqLine), .rxState(rxState), .busIdle(busIdle),
    .arbWon(arbWon), .txStart(txStart), .reqPending(reqPending), .pendKind(pendKind),
    .wonPulse(wonPulse), .lostPulse(lostPulse), .statActive(statActive), .statBit(statBit)
  );

  always #10 clk = ~clk;

  // {kind, rx during frame, expect pending}
  localparam logic [4:0] VEC [8] = '{
    {3'd1, 1'b0, 1'b1}, {3'd2, 1'b0, 1'b1}, {3'd3, 1'b0, 1'b1}, {3'd4, 1'b0, 1'b1},
    {3'd3, 1'b1, 1'b0}, {3'd4, 1'b1, 1'b0}, {3'd1, 1'b1, 1'b1}, {3'd2, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sendFrame(input logic [2:0] t, input logic [3:0] a, input logic [7:0] d,
                           input logic rx);
    logic [16:0] bits;
    int n;
    if (t == 3'd5 || t == 3'd6) begin bits = {1'b1, t, a, d, 1'b0}; n = 17; end
    else begin bits = {1'b1, t, 4'b0000, 9'b0}; n = 8; end
    for (int i = 0; i < n; i++) begin
      reqLine = bits[16-i];
      if (rx) rxState = 1'b1;
      @(negedge clk);
    end
    reqLine = 1'b0;
    @(negedge clk);
  endtask

  task automatic readBits(input string req, output logic [11:0] v);
    v = '0;
    for (int i = 0; i < 12; i++) begin
      chk(req, 16'(statActive), 16'd1);
      v = {v[10:0], statBit};
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 pending", 16'(reqPending), 0);
    chk("R10 kind", 16'(pendKind), 0);
    chk("R10 pulses", 16'({wonPulse, lostPulse}), 0);
    chk("R10 status", 16'({statActive, statBit}), 0);

    // R1 R3 R4 R6 vector walk
    for (int i = 0; i < 8; i++) begin
      logic [2:0] k;
      k = VEC[i][4:2];
      sendFrame(k, 4'h0, 8'h00, VEC[i][1]);
      rxState = 1'b0;
      chk("R1/R3 pending", 16'(reqPending), 16'(VEC[i][0]));
      chk("R1 kind", 16'(pendKind), VEC[i][0] ? 16'(k) : 16'd0);
      if (VEC[i][0]) begin
        arbWon = 1'b1;
        @(negedge clk);
        arbWon = 1'b0;
        chk("R4 won", 16'(wonPulse), 1);
        if (k == 3'd2) begin
          chk("R6 held after win", 16'(reqPending), 1);
          txStart = 1'b1;
          @(negedge clk);
          txStart = 1'b0;
        end
        chk("R4/R6 cleared", 16'(reqPending), 0);
      end
      @(negedge clk);
    end

    // R2 second request ignored
    sendFrame(3'd4, 4'h0, 8'h00, 1'b0);
    sendFrame(3'd3, 4'h0, 8'h00, 1'b0);
    chk("R2 kind kept", 16'(pendKind), 16'd4);
    arbWon = 1'b1; @(negedge clk); arbWon = 1'b0;
    chk("R2 won", 16'(wonPulse), 1);

    // R5 loss on rising receive
    sendFrame(3'd4, 4'h0, 8'h00, 1'b0);
    rxState = 1'b1; @(negedge clk);
    chk("R5 lost", 16'(lostPulse), 1);
    chk("R5 cleared", 16'(reqPending), 0);
    rxState = 1'b0; @(negedge clk);
    chk("R5 lost one cycle", 16'(lostPulse), 0);
    sendFrame(3'd1, 4'h0, 8'h00, 1'b1);  // receive stays high
    repeat (3) @(negedge clk);
    chk("R5 steady rx keeps imm", 16'(reqPending), 1);
    chk("R5 no loss", 16'(lostPulse), 0);
    rxState = 1'b0; @(negedge clk);
    rxState = 1'b1; @(negedge clk);
    chk("R5 imm lost", 16'(lostPulse), 1);
    rxState = 1'b0; @(negedge clk);

    // R6 iso ignores receive, idle timeout
    sendFrame(3'd2, 4'h0, 8'h00, 1'b0);
    rxState = 1'b1; @(negedge clk);
    chk("R6 rx ignored", 16'({reqPending, lostPulse}), 16'b10);
    rxState = 1'b0;
    arbWon = 1'b1; @(negedge clk); arbWon = 1'b0;
    chk("R6 won", 16'({wonPulse, reqPending}), 16'b11);
    busIdle = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 still held", 16'(reqPending), 1);
    end
    @(negedge clk);
    chk("R6 idle timeout", 16'(reqPending), 0);
    busIdle = 1'b0;

    // R7 R8 write then read back
    sendFrame(3'd6, 4'h5, 8'hA5, 1'b0);
    sendFrame(3'd6, 4'h0, 8'h3C, 1'b0);
    sendFrame(3'd5, 4'h5, 8'h00, 1'b0);
    chk("R8 waits for idle", 16'(statActive), 0);
    busIdle = 1'b1; @(negedge clk);
    readBits("R8 active", got);
    chk("R7/R8 read data", 16'(got), 16'h5A5);
    chk("R8 ends", 16'(statActive), 0);
    busIdle = 1'b0;
    sendFrame(3'd5, 4'h9, 8'h00, 1'b0);
    busIdle = 1'b1; @(negedge clk);
    readBits("R10 active", got);
    chk("R10 reg zero", 16'(got), 16'h900);
    busIdle = 1'b0;

    // R9 interrupted status transfer is retried
    sendFrame(3'd5, 4'h0, 8'h00, 1'b0);
    busIdle = 1'b1; @(negedge clk);
    repeat (3) @(negedge clk);
    rxState = 1'b1; @(negedge clk);
    chk("R9 aborted", 16'(statActive), 0);
    rxState = 1'b0; @(negedge clk);
    readBits("R9 retry active", got);
    chk("R9 retry data", 16'(got), 16'h03C);
    busIdle = 1'b0;

    // R9 read arriving while one unanswered is ignored
    sendFrame(3'd5, 4'h5, 8'h00, 1'b0);
    sendFrame(3'd5, 4'h0, 8'h00, 1'b0);
    busIdle = 1'b1; @(negedge clk);
    readBits("R9 first read", got);
    chk("R9 first data", 16'(got), 16'h5A5);
    repeat (2) @(negedge clk);
    chk("R9 second dropped", 16'(statActive), 0);
    busIdle = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule